// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block keeps a small, fully associative store of recent virtual-page-to-frame translations, so that most memory accesses do not need a page-table walk. Each slot holds a virtual page number, the address-space identifier (ASID) of the process that owns it, the physical frame number, and two flags: writable and dirty. Because the ASID is part of the tag, translations for several processes can stay resident together. Isolation between processes then comes from the tag match. A flush of everything, or of one ASID, is the other way to get it.

A lookup presents an ASID, a page number and a read/write indication. The key is compared against every slot at once. One cycle later the block returns hit plus the frame number, or a miss. A write that finds a slot which is read-only or not yet dirty is reported as a miss, so the page walker can update the page table and refill the slot. Refills come from the walker and use this priority: a slot that already holds the same tag, then the lowest free slot, then a round-robin victim.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is invalid, every lookup misses, and rsp_valid and rsp_hit are low.
- R2: rsp_valid is req_valid delayed by one cycle, and rsp_hit and rsp_pfn belong to the request of the previous cycle. rsp_pfn is zero whenever rsp_hit is low.
- R3: A lookup hits only a valid slot whose ASID and page number both equal the key. The same page number under another ASID misses.
- R4: A read lookup (req_write=0) ignores the flags. A write lookup (req_write=1) hits only when the matching slot has writable=1 and dirty=1, and otherwise reports a miss.
- R5: A refill whose tag is not present writes into the lowest-numbered invalid slot when one exists.
- R6: When all slots are valid, a new tag goes to the slot named by a round-robin pointer. The pointer is 0 after reset and steps by one, wrapping at the last slot, only after such a replacement.
- R7: A refill whose ASID and page number match a valid slot overwrites that slot's frame and flags in place. It uses no other slot and leaves the pointer unchanged.
- R8: flush_all invalidates every slot in one cycle, so lookups from the next cycle on miss.
- R9: A flush by ASID invalidates exactly the slots tagged with flush_asid, and all other slots keep hitting.
- R10: A refill in the same cycle as either flush is dropped. A lookup in the same cycle as a refill or flush sees the contents from before that cycle.
- R11: No key ever matches more than one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_write | input | 1 | Lookup is for a store |
| req_asid | input | ASID_W | Lookup address-space identifier |
| req_vpn | input | VPN_W | Lookup virtual page number |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_pfn | output | PFN_W | Frame number on hit, zero on miss |
| fill_valid | input | 1 | Refill from the page walker |
| fill_asid | input | ASID_W | Refill ASID |
| fill_vpn | input | VPN_W | Refill virtual page number |
| fill_pfn | input | PFN_W | Refill frame number |
| fill_writable | input | 1 | Refill writable flag |
| fill_dirty | input | 1 | Refill dirty flag |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_en | input | 1 | Invalidate the slots of one ASID |
| flush_asid | input | ASID_W | ASID to invalidate |

## Verification
The single-match property depends on every slot being written through the refill port. That port is the only path into the store, and its duplicate check is what keeps two slots from carrying the same tag. The assertions also assume the inputs are known after reset. The bench drives every input at the falling edge and never leaves a pin undriven. It loads slots only through refills, including refills that repeat an existing tag and refills that collide with flushes, and after each change it sweeps every key and access type of a four-slot configuration against a model built from the requirements.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef struct packed {
        logic writable;
        logic dirty;
    } tlb_perm_t;

    typedef enum logic [1:0] {
        WAY_DUP  = 2'd0,
        WAY_FREE = 2'd1,
        WAY_RR   = 2'd2
    } way_src_e;

endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
    parameter int ENTRIES = 64,
    parameter int ASID_W  = 8,
    parameter int VPN_W   = 20
) (
    input  logic [ENTRIES-1:0]             ent_valid,
    input  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
    input  logic [ASID_W-1:0]              key_asid,
    input  logic [VPN_W-1:0]               key_vpn,
    output logic [ENTRIES-1:0]             hits
);

    // one comparator per slot, all in parallel
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hits[i] = ent_valid[i]
                       && (ent_asid[i] == key_asid)
                       && (ent_vpn[i]  == key_vpn);
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [ENTRIES-1:0] dup_hits,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   way,
    output way_src_e           src
);

    logic [IDX_W-1:0] free_way;
    logic [IDX_W-1:0] dup_way;
    logic             free_any;
    logic             dup_any;

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        free_way = '0;
        dup_way  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) free_way = IDX_W'(i);
            if (dup_hits[i])   dup_way  = IDX_W'(i);
        end
        free_any = ~&ent_valid;
        dup_any  = |dup_hits;
    end

    always_comb begin
        if (dup_any) begin
            way = dup_way;
            src = WAY_DUP;
        end else if (free_any) begin
            way = free_way;
            src = WAY_FREE;
        end else begin
            way = rr_ptr;
            src = WAY_RR;
        end
    end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int ASID_W  = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [VPN_W-1:0]  req_vpn,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PFN_W-1:0]  rsp_pfn,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_writable,
    input  logic              fill_dirty,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][ASID_W-1:0] asid;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][PFN_W-1:0]  pfn;
        tlb_perm_t [ENTRIES-1:0]        perm;
        logic [IDX_W-1:0]               rr;
        logic                           rsp_valid;
        logic                           rsp_hit;
        logic [PFN_W-1:0]               rsp_pfn;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0] look_hits;
    logic [ENTRIES-1:0] fill_hits;
    logic [IDX_W-1:0]   fill_way;
    way_src_e           fill_src;

    logic [PFN_W-1:0]   sel_pfn;
    logic               sel_w;
    logic               sel_d;
    logic               look_ok;

    // lookup key against the stored tags
    tlb_tag_match #(
        .ENTRIES (ENTRIES),
        .ASID_W  (ASID_W),
        .VPN_W   (VPN_W)
    ) u_look_match (
        .ent_valid (st_q.valid),
        .ent_asid  (st_q.asid),
        .ent_vpn   (st_q.vpn),
        .key_asid  (req_asid),
        .key_vpn   (req_vpn),
        .hits      (look_hits)
    );

    // refill key against the stored tags (duplicate detection)
    tlb_tag_match #(
        .ENTRIES (ENTRIES),
        .ASID_W  (ASID_W),
        .VPN_W   (VPN_W)
    ) u_fill_match (
        .ent_valid (st_q.valid),
        .ent_asid  (st_q.asid),
        .ent_vpn   (st_q.vpn),
        .key_asid  (fill_asid),
        .key_vpn   (fill_vpn),
        .hits      (fill_hits)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES)
    ) u_victim (
        .ent_valid (st_q.valid),
        .dup_hits  (fill_hits),
        .rr_ptr    (st_q.rr),
        .way       (fill_way),
        .src       (fill_src)
    );

    // one-hot read-out of the matching slot
    always_comb begin
        sel_pfn = '0;
        sel_w   = 1'b0;
        sel_d   = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_hits[i]) begin
                sel_pfn = sel_pfn | st_q.pfn[i];
                sel_w   = sel_w   | st_q.perm[i].writable;
                sel_d   = sel_d   | st_q.perm[i].dirty;
            end
        end
        look_ok = (|look_hits) && (!req_write || (sel_w && sel_d));
    end

    always_comb begin
        st_d = st_q;

        // response stage, computed from pre-update contents
        st_d.rsp_valid = req_valid;
        st_d.rsp_hit   = req_valid && look_ok;
        st_d.rsp_pfn   = (req_valid && look_ok) ? sel_pfn : '0;

        // maintenance: flush beats refill
        if (flush_all) begin
            st_d.valid = '0;
        end else if (flush_asid_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (st_q.asid[i] == flush_asid) st_d.valid[i] = 1'b0;
            end
        end else if (fill_valid) begin
            st_d.valid[fill_way]         = 1'b1;
            st_d.asid[fill_way]          = fill_asid;
            st_d.vpn[fill_way]           = fill_vpn;
            st_d.pfn[fill_way]           = fill_pfn;
            st_d.perm[fill_way].writable = fill_writable;
            st_d.perm[fill_way].dirty    = fill_dirty;
            if (fill_src == WAY_RR) begin
                st_d.rr = (st_q.rr == LAST_IDX) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_pfn   = st_q.rsp_pfn;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2

    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit)); // R2

    AST_MISS_ZERO_PFN: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_pfn == '0)); // R2

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_hits)); // R11

    AST_FLUSH_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (st_q.valid == '0)); // R8

    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush_all && !flush_asid_en) |=> (st_q.valid != '0)); // R5

endmodule

// File: tb/asid_tlb_test.sv
module asid_tlb_test;

    localparam int ENT = 4;
    localparam int AW  = 2;
    localparam int VW  = 4;
    localparam int PW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_asid = '0;
    logic [VW-1:0] req_vpn = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [PW-1:0] rsp_pfn;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_asid = '0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_pfn = '0;
    logic          fill_writable = 1'b0;
    logic          fill_dirty = 1'b0;
    logic          flush_all = 1'b0;
    logic          flush_asid_en = 1'b0;
    logic [AW-1:0] flush_asid = '0;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    asid_tlb #(.ENTRIES(ENT), .ASID_W(AW), .VPN_W(VW), .PFN_W(PW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_asid(req_asid), .req_vpn(req_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn),
        .fill_valid(fill_valid), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_writable(fill_writable), .fill_dirty(fill_dirty),
        .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
    );

    // requirement model
    logic          m_v [ENT];
    logic [AW-1:0] m_a [ENT];
    logic [VW-1:0] m_p [ENT];
    logic [PW-1:0] m_f [ENT];
    logic          m_w [ENT];
    logic          m_d [ENT];
    int            m_rr;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic void m_expect(input logic [AW-1:0] a, input logic [VW-1:0] p,
                                     input bit wr, output bit hit, output logic [PW-1:0] f);
        hit = 1'b0;
        f   = '0;
        for (int i = 0; i < ENT; i++) begin
            if (m_v[i] && m_a[i] == a && m_p[i] == p && (!wr || (m_w[i] && m_d[i]))) begin
                hit = 1'b1;
                f   = m_f[i];
            end
        end
    endfunction

    function automatic void m_fill(input logic [AW-1:0] a, input logic [VW-1:0] p,
                                   input logic [PW-1:0] f, input bit w, input bit d);
        int slot = -1;
        for (int i = ENT - 1; i >= 0; i--)
            if (m_v[i] && m_a[i] == a && m_p[i] == p) slot = i;        // R7
        if (slot < 0)
            for (int i = ENT - 1; i >= 0; i--) if (!m_v[i]) slot = i;  // R5
        if (slot < 0) begin                                            // R6
            slot = m_rr;
            m_rr = (m_rr + 1) % ENT;
        end
        m_v[slot] = 1'b1; m_a[slot] = a; m_p[slot] = p;
        m_f[slot] = f;    m_w[slot] = w; m_d[slot] = d;
    endfunction

    // all tasks start and end at a falling edge
    task automatic look(input logic [AW-1:0] a, input logic [VW-1:0] p, input bit wr,
                        input string req);
        bit exp_hit;
        logic [PW-1:0] exp_pfn;
        m_expect(a, p, wr, exp_hit, exp_pfn);
        req_valid = 1'b1; req_write = wr; req_asid = a; req_vpn = p;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1 && rsp_hit === exp_hit && rsp_pfn === exp_pfn, req,
              {rsp_valid, rsp_hit, rsp_pfn}, {1'b1, exp_hit, exp_pfn});
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < (1 << AW); a++)
            for (int p = 0; p < (1 << VW); p++)
                for (int wr = 0; wr < 2; wr++)
                    look(AW'(a), VW'(p), wr[0], req);
    endtask

    task automatic fill(input logic [AW-1:0] a, input logic [VW-1:0] p,
                        input logic [PW-1:0] f, input bit w, input bit d);
        fill_valid = 1'b1; fill_asid = a; fill_vpn = p;
        fill_pfn = f; fill_writable = w; fill_dirty = d;
        @(negedge clk);
        fill_valid = 1'b0;
        m_fill(a, p, f, w, d);
    endtask

    task automatic do_flush_asid(input logic [AW-1:0] a);
        flush_asid_en = 1'b1; flush_asid = a;
        @(negedge clk);
        flush_asid_en = 1'b0;
        for (int i = 0; i < ENT; i++) if (m_a[i] == a) m_v[i] = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENT; i++) begin
            m_v[i] = 0; m_a[i] = '0; m_p[i] = '0; m_f[i] = '0; m_w[i] = 0; m_d[i] = 0;
        end
        m_rr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(rsp_valid === 1'b0 && rsp_hit === 1'b0, "R1", {rsp_valid, rsp_hit}, 0);
        sweep("R1");

        // R2: idle cycle gives no response
        @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_pfn === '0, "R2", {rsp_valid, rsp_pfn}, 0);

        // R3/R4/R5: same page under several ASIDs, every flag combination
        fill(2'd0, 4'd3, 4'h5, 1'b1, 1'b1);
        fill(2'd1, 4'd3, 4'h6, 1'b1, 1'b0);
        fill(2'd2, 4'd7, 4'h9, 1'b0, 1'b0);
        fill(2'd3, 4'd15, 4'ha, 1'b0, 1'b1);
        sweep("R3/R4/R5");

        // R6: full store, round-robin victims 0 then 1
        fill(2'd0, 4'd1, 4'hb, 1'b1, 1'b1);
        fill(2'd1, 4'd2, 4'hc, 1'b1, 1'b1);
        sweep("R6");

        // R7: duplicate tag overwrites in place, pointer stays at 2
        fill(2'd0, 4'd1, 4'hd, 1'b1, 1'b0);
        sweep("R7");
        fill(2'd2, 4'd2, 4'he, 1'b1, 1'b1);
        sweep("R6/R7");

        // R10: lookup in the refill cycle sees old contents
        fill_valid = 1'b1; fill_asid = 2'd3; fill_vpn = 4'd4; fill_pfn = 4'h7;
        fill_writable = 1'b1; fill_dirty = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_asid = 2'd3; req_vpn = 4'd4;
        @(negedge clk);
        fill_valid = 1'b0; req_valid = 1'b0;
        check(rsp_valid === 1'b1 && rsp_hit === 1'b0, "R10", {rsp_valid, rsp_hit}, 2);
        m_fill(2'd3, 4'd4, 4'h7, 1'b1, 1'b1);
        look(2'd3, 4'd4, 1'b0, "R10");

        // R9: flush by ASID
        do_flush_asid(2'd1);
        sweep("R9");

        // R10: refill dropped when it meets a flush
        fill_valid = 1'b1; fill_asid = 2'd0; fill_vpn = 4'd9; fill_pfn = 4'h1;
        fill_writable = 1'b1; fill_dirty = 1'b1;
        do_flush_asid(2'd2);
        fill_valid = 1'b0;
        sweep("R10");

        // R8: flush everything
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        for (int i = 0; i < ENT; i++) m_v[i] = 1'b0;
        sweep("R8");

        // R5/R6: refill after flush lands in free slots, then pointer continues
        fill(2'd1, 4'd8, 4'h3, 1'b0, 1'b0);
        fill(2'd1, 4'd9, 4'h4, 1'b1, 1'b1);
        fill(2'd2, 4'd8, 4'h2, 1'b1, 1'b1);
        fill(2'd3, 4'd8, 4'h1, 1'b1, 1'b1);
        fill(2'd0, 4'd0, 4'hf, 1'b1, 1'b1);
        sweep("R5/R6");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule